// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block sits between the on-chip interrupt sources and the CPU's fetch logic. It takes 21 request lines: maskable peripheral and pin requests, a non-maskable pin, software interrupt, the traps and a reset request. It qualifies each line with its local enable and with the two global mask bits it keeps on behalf of the condition-code register. Among the qualified lines it picks the one with the highest priority.

The choice is taken only when the CPU signals an instruction boundary. The winning source number and its 16-bit vector address are then held until the CPU acknowledges. On that acknowledge the block sets the interrupt mask bit. It also sets the non-maskable mask bit when the non-maskable pin is asserted or the held source is the reset request. The CPU loads the mask bits through a small write port. The non-maskable mask can only be cleared that way, never set.

Top module: `irq_vector_resolver`

## Requirements
- R1: Request bit k of `reqIn` maps to vector address 0xFFD6 + 2·k and to `srcId` = k. The bits are: 0 serial comms, 1 serial peripheral transfer done, 2 pulse-accumulator edge, 3 pulse-accumulator overflow, 4 timer overflow, 5 capture 4 / compare 5, 6..9 compares 4, 3, 2, 1, 10..12 captures 3, 2, 1, 13 periodic tick, 14 external IRQ pin, 15 non-maskable pin, 16 software interrupt, 17 illegal opcode, 18 watchdog failure, 19 clock monitor failure, 20 reset request (0xFFFE).
- R2: Bits 0..14 are eligible only when `localEn[k]` is 1 and `maskI` is 0.
- R3: Bit 15 is eligible only when `maskX` is 0, regardless of `maskI`. Bits 16, 17 and 20 are always eligible. Bit 18 is blocked while `copDisable` is 1. Bit 19 needs `cmeEnable` = 1.
- R4: Among eligible bits, the highest bit number wins.
- R5: `irqPending` is 1 in the same cycle in which any bit is eligible, and 0 otherwise.
- R6: A vector is captured only on a clock edge where `boundary` is 1, no vector is held and some bit is eligible. `vecValid`, `vecAddr` and `srcId` then change at that edge.
- R7: While a vector is held, `vecAddr` and `srcId` stay unchanged until acknowledge. Further `boundary` strobes and request changes have no effect on them.
- R8: `ack` while a vector is held clears `vecValid`, `vecAddr` and `srcId` to 0 and sets `maskI`. It also sets `maskX` when `reqIn[15]` is 1 in that cycle or the held source is 20. `ack` with nothing held changes nothing.
- R9: `ccrWrite` loads `maskI` from `ccrWrI`. `maskX` becomes `maskX & ccrWrX`, so it can only be cleared. A mask set by an acknowledge in the same cycle overrides the write.
- R10: After `rst_n` low, `vecValid`, `vecAddr` and `srcId` are 0 and both `maskI` and `maskX` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqIn | input | 21 | Request lines, bit k per R1 |
| localEn | input | 15 | Local enables for bits 0..14 |
| copDisable | input | 1 | Blocks the watchdog-failure request |
| cmeEnable | input | 1 | Enables the clock-monitor request |
| boundary | input | 1 | Instruction-boundary strobe |
| ack | input | 1 | CPU has taken the held vector |
| ccrWrite | input | 1 | Mask write strobe |
| ccrWrI | input | 1 | New value for maskI |
| ccrWrX | input | 1 | New value for maskX (clear only) |
| irqPending | output | 1 | Some source is eligible now |
| vecValid | output | 1 | A vector is held |
| vecAddr | output | 16 | Held vector address, 0 when none |
| srcId | output | 5 | Held source number, 0 when none |
| maskI | output | 1 | Global maskable-interrupt mask |
| maskX | output | 1 | Non-maskable pin mask |

## Verification
An acknowledge and a mask write can land on the same edge. When they do, the set from the acknowledge must beat a write that tries to clear `maskI`, and a write that tries to set `maskX` must still be refused. The bench holds a vector, then drives `ack` together with `ccrWrite` carrying the opposite values. One clock later it reads both mask outputs at the ports. A boundary strobe that meets a held vector is provoked in the same way: a higher-priority request is raised and strobed, and the bench confirms that the held source number and address do not move.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_SRC      = 21;
  localparam int NUM_MASKABLE = 15;
  localparam int SRC_W        = $clog2(NUM_SRC);
  localparam int VEC_W        = 16;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFD6;

  localparam int IDX_XIRQ   = NUM_MASKABLE;
  localparam int IDX_SWI    = NUM_MASKABLE + 1;
  localparam int IDX_ILLOP  = NUM_MASKABLE + 2;
  localparam int IDX_WDOG   = NUM_MASKABLE + 3;
  localparam int IDX_CLKMON = NUM_MASKABLE + 4;
  localparam int IDX_RESET  = NUM_MASKABLE + 5;

  typedef struct packed {
    logic latchVec;
    logic clearVec;
    logic setMaskI;
    logic setMaskX;
  } ctlStrobe_t;
endpackage

// File: rtl/irqv_dpath.sv
module irqv_dpath
  import irqv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [NUM_MASKABLE-1:0] localEn,
  input  logic               copDisable,
  input  logic               cmeEnable,
  input  logic               ccrWrite,
  input  logic               ccrWrI,
  input  logic               ccrWrX,
  input  ctlStrobe_t         ctl,
  output logic               anyElig,
  output logic               xirqLine,
  output logic               heldIsReset,
  output logic [VEC_W-1:0]   vecAddr,
  output logic [SRC_W-1:0]   srcId,
  output logic               maskI,
  output logic               maskX
);
  logic [NUM_SRC-1:0] elig;
  logic [SRC_W-1:0]   winner;
  logic [VEC_W-1:0]   winnerVec;

  // qualification of the maskable group, one line per source
  for (genvar g = 0; g < NUM_MASKABLE; g++) begin : g_maskable
    assign elig[g] = reqIn[g] & localEn[g] & ~maskI;
  end
  assign elig[IDX_XIRQ]   = reqIn[IDX_XIRQ] & ~maskX;
  assign elig[IDX_SWI]    = reqIn[IDX_SWI];
  assign elig[IDX_ILLOP]  = reqIn[IDX_ILLOP];
  assign elig[IDX_WDOG]   = reqIn[IDX_WDOG] & ~copDisable;
  assign elig[IDX_CLKMON] = reqIn[IDX_CLKMON] & cmeEnable;
  assign elig[IDX_RESET]  = reqIn[IDX_RESET];

  // ascending scan: the last (highest) eligible index wins
  always_comb begin
    winner = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (elig[k]) winner = SRC_W'(k);
    end
  end

  assign winnerVec   = VEC_BASE + (VEC_W'(winner) << 1);
  assign anyElig     = |elig;
  assign xirqLine    = reqIn[IDX_XIRQ];
  assign heldIsReset = (srcId == SRC_W'(IDX_RESET));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecAddr <= '0;
      srcId   <= '0;
    end else if (ctl.latchVec) begin
      vecAddr <= winnerVec;
      srcId   <= winner;
    end else if (ctl.clearVec) begin
      vecAddr <= '0;
      srcId   <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskI <= 1'b1;
      maskX <= 1'b1;
    end else begin
      if (ctl.setMaskI)   maskI <= 1'b1;
      else if (ccrWrite)  maskI <= ccrWrI;
      if (ctl.setMaskX)   maskX <= 1'b1;
      else if (ccrWrite)  maskX <= maskX & ccrWrX;
    end
  end

  p_ack_sets_i_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.setMaskI |=> maskI);

  p_x_never_set_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!maskX && !ctl.setMaskX) |=> !maskX);
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic       ack,
  input  logic       anyElig,
  input  logic       xirqLine,
  input  logic       heldIsReset,
  output ctlStrobe_t ctl,
  output logic       vecValid
);
  always_comb begin
    ctl.latchVec = boundary & ~vecValid & anyElig;
    ctl.clearVec = ack & vecValid;
    ctl.setMaskI = ctl.clearVec;
    ctl.setMaskX = ctl.clearVec & (xirqLine | heldIsReset);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             vecValid <= 1'b0;
    else if (ctl.latchVec)  vecValid <= 1'b1;
    else if (ctl.clearVec)  vecValid <= 1'b0;
  end

  p_held_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !ack) |=> vecValid);

  p_no_capture_off_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!vecValid && !boundary) |=> !vecValid);
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
  import irqv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [20:0] reqIn,
  input  logic [14:0] localEn,
  input  logic        copDisable,
  input  logic        cmeEnable,
  input  logic        boundary,
  input  logic        ack,
  input  logic        ccrWrite,
  input  logic        ccrWrI,
  input  logic        ccrWrX,
  output logic        irqPending,
  output logic        vecValid,
  output logic [15:0] vecAddr,
  output logic [4:0]  srcId,
  output logic        maskI,
  output logic        maskX
);
  ctlStrobe_t ctl;
  logic anyElig, xirqLine, heldIsReset;

  irqv_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .localEn(localEn),
    .copDisable(copDisable), .cmeEnable(cmeEnable),
    .ccrWrite(ccrWrite), .ccrWrI(ccrWrI), .ccrWrX(ccrWrX), .ctl(ctl),
    .anyElig(anyElig), .xirqLine(xirqLine), .heldIsReset(heldIsReset),
    .vecAddr(vecAddr), .srcId(srcId), .maskI(maskI), .maskX(maskX)
  );

  irqv_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .ack(ack),
    .anyElig(anyElig), .xirqLine(xirqLine), .heldIsReset(heldIsReset),
    .ctl(ctl), .vecValid(vecValid)
  );

  assign irqPending = anyElig;

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !ack) |=> ($stable(vecAddr) && $stable(srcId)));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vecValid |-> (vecAddr == '0 && srcId == '0));

  p_vector_matches_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> (vecAddr == VEC_W'(VEC_BASE + (VEC_W'(srcId) << 1))));
endmodule

// File: tb/irq_vector_resolver_bench.sv
`timescale 1ns/1ps
module irq_vector_resolver_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [20:0] reqIn = '0;
  logic [14:0] localEn = '0;
  logic copDisable = 1'b0, cmeEnable = 1'b0, boundary = 1'b0, ack = 1'b0;
  logic ccrWrite = 1'b0, ccrWrI = 1'b0, ccrWrX = 1'b0;
  logic irqPending, vecValid, maskI, maskX;
  logic [15:0] vecAddr;
  logic [4:0] srcId;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_resolver u_irq_vector_resolver (.*);

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setMasks(input logic i, input logic x);
    ccrWrite = 1; ccrWrI = i; ccrWrX = x; tick(); ccrWrite = 0;
  endtask

  task automatic strobe(); boundary = 1; tick(); boundary = 0; endtask
  task automatic doAck();  ack = 1; tick(); ack = 0; endtask

  task automatic t_reset();
    chk("R10 vecValid", vecValid, 0); chk("R10 vecAddr", vecAddr, 0);
    chk("R10 srcId", srcId, 0); chk("R10 maskI", maskI, 1); chk("R10 maskX", maskX, 1);
  endtask

  task automatic t_vector_map();
    localEn = '1; cmeEnable = 1; copDisable = 0;
    for (int k = 0; k < 21; k++) begin
      setMasks(0, 0);
      reqIn = 21'(1) << k;
      strobe();
      chk($sformatf("R1 valid src%0d", k), vecValid, 1);
      chk($sformatf("R1 addr src%0d", k), vecAddr, 16'hFFD6 + 2*k);
      chk($sformatf("R1 id src%0d", k), srcId, k);
      reqIn = '0;
      doAck();
      chk($sformatf("R8 cleared src%0d", k), vecValid, 0);
      chk($sformatf("R8 maskI src%0d", k), maskI, 1);
      chk($sformatf("R8 maskX src%0d", k), maskX, (k == 20) ? 1 : 0);
    end
  endtask

  task automatic t_masking();
    setMasks(0, 0); localEn = '0; reqIn = 21'(1) << 3; #1;
    chk("R2 local enable off", irqPending, 0);
    localEn = '1; #1; chk("R2 enabled", irqPending, 1);
    setMasks(1, 0); chk("R2 maskI blocks", irqPending, 0);
    strobe(); chk("R6 no capture when none eligible", vecValid, 0);
    reqIn = 21'(1) << 15; #1; chk("R3 xirq with maskI set", irqPending, 1);
    setMasks(1, 0); ccrWrX = 1;
    reqIn = 21'(1) << 18; copDisable = 1; #1; chk("R3 watchdog disabled", irqPending, 0);
    copDisable = 0; #1; chk("R3 watchdog enabled", irqPending, 1);
    reqIn = 21'(1) << 19; cmeEnable = 0; #1; chk("R3 clkmon off", irqPending, 0);
    cmeEnable = 1; #1; chk("R5 clkmon on", irqPending, 1);
    reqIn = 21'(1) << 16; #1; chk("R3 swi unmasked", irqPending, 1);
    reqIn = '0; #1; chk("R5 idle", irqPending, 0);
  endtask

  task automatic t_priority();
    setMasks(0, 0); localEn = '1; cmeEnable = 0;
    reqIn = (21'(1) << 0) | (21'(1) << 5) | (21'(1) << 14);
    strobe(); chk("R4 maskable pick", srcId, 14); chk("R4 addr", vecAddr, 16'hFFF2);
    reqIn = '0; doAck();
    setMasks(0, 0);
    reqIn = (21'(1) << 15) | (21'(1) << 16) | (21'(1) << 19);
    strobe(); chk("R4 clkmon gated out", srcId, 16);
    reqIn = '0; doAck(); cmeEnable = 1;
  endtask

  task automatic t_hold();
    setMasks(0, 0); reqIn = 21'(1) << 3; strobe();
    chk("R6 captured", srcId, 3);
    reqIn = 21'(1) << 20; strobe();
    chk("R7 id held", srcId, 3); chk("R7 addr held", vecAddr, 16'hFFDC);
    reqIn = '0; tick(); chk("R7 still valid", vecValid, 1);
    doAck(); chk("R8 addr cleared", vecAddr, 0); chk("R8 id cleared", srcId, 0);
  endtask

  task automatic t_ack_cases();
    setMasks(0, 0); doAck();
    chk("R8 stray ack maskI", maskI, 0); chk("R8 stray ack maskX", maskX, 0);
    reqIn = 21'(1) << 15; strobe(); chk("R8 xirq held", srcId, 15);
    doAck(); chk("R8 xirq sets maskX", maskX, 1);
    reqIn = '0;
  endtask

  task automatic t_collision();
    setMasks(0, 0); reqIn = 21'(1) << 7; strobe(); reqIn = '0;
    ack = 1; ccrWrite = 1; ccrWrI = 0; ccrWrX = 1; tick(); ack = 0; ccrWrite = 0;
    chk("R9 ack beats write maskI", maskI, 1);
    chk("R9 write cannot set maskX", maskX, 0);
    setMasks(0, 1); chk("R9 write loads maskI", maskI, 0);
    chk("R9 maskX stays clear", maskX, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset(); t_vector_map(); t_masking(); t_priority();
    t_hold(); t_ack_cases(); t_collision();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule